// File: doc/BRIEF.md
# Flash Command Sequence Checker

This block sits in front of an embedded flash controller and polices the way a CPU builds a flash command. It watches bus writes into the flash array window and into four small control registers. A command is accepted only in a fixed order: a word is latched from an array write, then an operation code is written to the command register, then the buffer-empty flag is cleared through the status register to launch the operation. Anything done out of order, misaligned, or aimed at memory this block does not own aborts the sequence and sets a sticky access-error flag.

A launched operation is handed to a simple program/erase timer model. The model holds the buffer-empty and done flags low for a parameter-set number of cycles and then raises them again. Entering stop mode while an operation runs kills it and flags an access error.

Register indices on `reg_idx` are: 0 clock divider, 1 configuration, 2 status, 3 command. In a status write, bit 7 set launches a pending command and bit 4 set clears the access-error flag. Known operation codes are 0x05 (erase verify), 0x20 (word program), 0x40 (sector erase) and 0x41 (mass erase).

Top module: `flash_seq_guard`

## Requirements
- R1: After reset, `buf_empty` and `cmd_done` are 1, and `acc_err` and `launch` are 0.
- R2: An aligned word array write, then a code write to index 3, then a status write (index 2) with bit 7 set, together produce a one-cycle `launch` pulse on the edge of the status write. That pulse carries the latched address, data and code, and `buf_empty` and `cmd_done` drop to 0 on the same edge.
- R3: A launched operation keeps `buf_empty` and `cmd_done` at 0 for `ERASE_CYCLES` cycles for codes 0x40 and 0x41, and for `PROG_CYCLES` cycles for any other code. Both flags then return to 1.
- R4: An array write made before any write to the clock divider register (index 0) sets `acc_err`.
- R5: A byte array write, or a word array write to an odd address, sets `acc_err`.
- R6: An array write while an operation runs (`buf_empty` = 0) sets `acc_err`, and the running operation still completes on its original schedule.
- R7: A second array write before the latched word's command has been launched sets `acc_err` and discards the whole pending sequence.
- R8: With a word latched, a write to register index 0, 1 or 2 sets `acc_err` and aborts the sequence.
- R9: With a code already latched, a second code write sets `acc_err`. Outside special mode, an unknown code sets `acc_err`. In special mode, an unknown code is accepted and runs as a short operation.
- R10: With a code latched, a write to register index 0, 1 or 3 sets `acc_err` and aborts the sequence.
- R11: Outside special mode, any array write while `blk_sel` differs from `BLK_ID` sets `acc_err`. In special mode, a write to 0x8000 to 0xBFFF sets `acc_err` unless `blk_sel` equals `BLK_ID` and `page_sel` lies in [`PAGE_BASE`, `PAGE_BASE`+`NUM_PAGES`). Special-mode writes outside that window are not checked against the page.
- R12: `stop_req` high while an operation runs ends it on the next edge, with `buf_empty` = `cmd_done` = 1 and `acc_err` = 1. `stop_req` high with a word or code pending discards the sequence without setting `acc_err`.
- R13: `acc_err` stays set until a status write with bit 4 set. While it is set, array writes are ignored, so no sequence can start and no launch happens.
- R14: A code write or a launching status write with no word latched has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_special | input | 1 | 1 selects special mode |
| page_sel | input | PAGE_W | Current page register value |
| blk_sel | input | 1 | Block-select bit |
| stop_req | input | 1 | Stop-mode entry request (level) |
| arr_wr | input | 1 | Write strobe into flash array space |
| arr_byte | input | 1 | The array write is a byte access |
| arr_addr | input | 16 | Array write address |
| arr_wdata | input | DATA_W | Array write data |
| reg_wr | input | 1 | Write strobe to control registers |
| reg_idx | input | 2 | Register index (0 divider, 1 config, 2 status, 3 command) |
| reg_wdata | input | 8 | Register write data |
| buf_empty | output | 1 | Command buffer empty flag |
| cmd_done | output | 1 | Command complete flag |
| acc_err | output | 1 | Sticky access-error flag |
| launch | output | 1 | One-cycle pulse when an operation starts |
| launch_cmd | output | 8 | Code of the launched operation |
| launch_addr | output | 16 | Address of the launched operation |
| launch_data | output | DATA_W | Data word of the launched operation |

## Verification
The bench drives corner cases where a lax sequencer would still launch. Examples are a code write or launch with no word, a launch attempt after a double word write, and a fresh sequence started while the error flag is still set. A design that fails to discard state here emits a spurious `launch` pulse. Other tests put an array write into the middle of a running operation, or raise stop in one. A design that restarts or forgets to abort shows a wrong busy length or a missing error. The mapping tests move only one of page, block bit, window and mode at a time, so an inverted or missing term in the decode shows up as a wrong `acc_err`. The special-mode unknown code checks that code filtering depends on mode.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WORD = 2'd1,
      ST_CMD  = 2'd2,
      ST_RUN  = 2'd3
   } seq_st_t;

   localparam logic [1:0] RIX_DIV  = 2'd0;
   localparam logic [1:0] RIX_CFG  = 2'd1;
   localparam logic [1:0] RIX_STAT = 2'd2;
   localparam logic [1:0] RIX_CMD  = 2'd3;

   localparam int STB_LAUNCH = 7;
   localparam int STB_ERRCLR = 4;

   localparam logic [7:0] OP_VERIFY = 8'h05;
   localparam logic [7:0] OP_PROG   = 8'h20;
   localparam logic [7:0] OP_SECT   = 8'h40;
   localparam logic [7:0] OP_MASS   = 8'h41;

   function automatic logic op_known(input logic [7:0] c);
      return (c == OP_VERIFY) || (c == OP_PROG) || (c == OP_SECT) || (c == OP_MASS);
   endfunction

   function automatic logic op_long(input logic [7:0] c);
      return (c == OP_SECT) || (c == OP_MASS);
   endfunction

endpackage

// File: rtl/fseq_map.sv
module fseq_map #(
   parameter int PAGE_W    = 6,
   parameter int PAGE_BASE = 60,
   parameter int NUM_PAGES = 4,
   parameter bit BLK_ID    = 1'b0
) (
   input  logic [1:0]        addr_hi,
   input  logic              special,
   input  logic [PAGE_W-1:0] page_sel,
   input  logic              blk_sel,
   output logic              map_ok
);
   localparam int PG_LOG  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 0;
   localparam bit ALIGNED = (NUM_PAGES == (1 << PG_LOG)) && ((PAGE_BASE % NUM_PAGES) == 0);

   if (NUM_PAGES < 1)
      $error("fseq_map: NUM_PAGES must be at least 1");
   if (PAGE_BASE + NUM_PAGES > (1 << PAGE_W))
      $error("fseq_map: page range does not fit in PAGE_W bits");

   logic page_ok;
   logic blk_ok;
   logic in_win;

   if (ALIGNED) begin : g_mask
      localparam logic [PAGE_W-1:0] BASE_V = PAGE_W'(PAGE_BASE);
      localparam logic [PAGE_W-1:0] MASK_V = ~PAGE_W'(NUM_PAGES - 1);
      assign page_ok = ((page_sel ^ BASE_V) & MASK_V) == '0;
   end else begin : g_range
      localparam logic [PAGE_W:0] LO_V = (PAGE_W+1)'(PAGE_BASE);
      localparam logic [PAGE_W:0] HI_V = (PAGE_W+1)'(PAGE_BASE + NUM_PAGES);
      assign page_ok = ({1'b0, page_sel} >= LO_V) && ({1'b0, page_sel} < HI_V);
   end

   assign blk_ok = (blk_sel == BLK_ID);
   assign in_win = (addr_hi == 2'b10);
   assign map_ok = special ? (!in_win || (blk_ok && page_ok)) : blk_ok;

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
   parameter int PROG_CYCLES  = 16,
   parameter int ERASE_CYCLES = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic long_op,
   output logic done
);
   localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CNT_W = $clog2(MAXC + 1);

   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1)
      $error("fseq_timer: cycle counts must be at least 1");

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] load_v;

   if (PROG_CYCLES == ERASE_CYCLES) begin : g_one
      logic unused_sel;
      assign unused_sel = long_op;
      assign load_v = CNT_W'(PROG_CYCLES - 1);
   end else begin : g_two
      assign load_v = long_op ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (start)       cnt <= load_v;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
   import fseq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special,
   input  logic              map_ok,
   input  logic              stop_req,
   input  logic              arr_wr,
   input  logic              arr_byte,
   input  logic [15:0]       arr_addr,
   input  logic [DATA_W-1:0] arr_wdata,
   input  logic              reg_wr,
   input  logic [1:0]        reg_idx,
   input  logic [7:0]        reg_wdata,
   input  logic              tmr_done,
   output seq_st_t           st,
   output logic              acc_err,
   output logic              launch,
   output logic [7:0]        l_cmd,
   output logic [15:0]       l_addr,
   output logic [DATA_W-1:0] l_data,
   output logic              tmr_start,
   output logic              tmr_long
);
   seq_st_t nst;
   logic    div_set, div_n;
   logic    err, clr, go, ld_word, ld_cmd;
   logic    pending;

   assign pending = (st == ST_WORD) || (st == ST_CMD);

   always_comb begin
      nst     = st;
      div_n   = div_set;
      err     = 1'b0;
      clr     = 1'b0;
      go      = 1'b0;
      ld_word = 1'b0;
      ld_cmd  = 1'b0;
      if (stop_req && st != ST_IDLE) begin
         nst = ST_IDLE;
         err = (st == ST_RUN);
      end else begin
         if (st == ST_RUN && tmr_done) nst = ST_IDLE;
         if (arr_wr) begin
            if (!acc_err) begin
               if (st != ST_IDLE || !div_set || arr_byte || arr_addr[0] || !map_ok) begin
                  err = 1'b1;
               end else begin
                  ld_word = 1'b1;
                  nst     = ST_WORD;
               end
            end
         end else if (reg_wr) begin
            unique case (reg_idx)
               RIX_DIV, RIX_CFG: begin
                  if (pending)                 err   = 1'b1;
                  else if (reg_idx == RIX_DIV) div_n = 1'b1;
               end
               RIX_CMD: begin
                  if (st == ST_WORD) begin
                     if (op_known(reg_wdata) || special) begin
                        ld_cmd = 1'b1;
                        nst    = ST_CMD;
                     end else begin
                        err = 1'b1;
                     end
                  end else if (st == ST_CMD) begin
                     err = 1'b1;
                  end
               end
               default: begin
                  if (st == ST_WORD) begin
                     err = 1'b1;
                  end else if (st == ST_CMD) begin
                     if (reg_wdata[STB_LAUNCH]) begin
                        go  = 1'b1;
                        nst = ST_RUN;
                     end
                  end else if (reg_wdata[STB_ERRCLR]) begin
                     clr = 1'b1;
                  end
               end
            endcase
         end
         if (err && st != ST_RUN) nst = ST_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         div_set <= 1'b0;
         acc_err <= 1'b0;
         launch  <= 1'b0;
         l_cmd   <= '0;
         l_addr  <= '0;
         l_data  <= '0;
      end else begin
         st      <= nst;
         div_set <= div_n;
         launch  <= go;
         if (err)      acc_err <= 1'b1;
         else if (clr) acc_err <= 1'b0;
         if (ld_word) begin
            l_addr <= arr_addr;
            l_data <= arr_wdata;
         end
         if (ld_cmd) l_cmd <= reg_wdata;
      end
   end

   assign tmr_start = go;
   assign tmr_long  = op_long(l_cmd);

endmodule

// File: rtl/flash_seq_guard.sv
module flash_seq_guard
   import fseq_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int PAGE_W       = 6,
   parameter int PAGE_BASE    = 60,
   parameter int NUM_PAGES    = 4,
   parameter bit BLK_ID       = 1'b0,
   parameter int PROG_CYCLES  = 16,
   parameter int ERASE_CYCLES = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_special,
   input  logic [PAGE_W-1:0] page_sel,
   input  logic              blk_sel,
   input  logic              stop_req,
   input  logic              arr_wr,
   input  logic              arr_byte,
   input  logic [15:0]       arr_addr,
   input  logic [DATA_W-1:0] arr_wdata,
   input  logic              reg_wr,
   input  logic [1:0]        reg_idx,
   input  logic [7:0]        reg_wdata,
   output logic              buf_empty,
   output logic              cmd_done,
   output logic              acc_err,
   output logic              launch,
   output logic [7:0]        launch_cmd,
   output logic [15:0]       launch_addr,
   output logic [DATA_W-1:0] launch_data
);
   if (DATA_W < 8)
      $error("flash_seq_guard: DATA_W must be at least 8");

   seq_st_t st;
   logic    map_ok, tmr_done, tmr_start, tmr_long;

   fseq_map #(
      .PAGE_W(PAGE_W), .PAGE_BASE(PAGE_BASE), .NUM_PAGES(NUM_PAGES), .BLK_ID(BLK_ID)
   ) map_i (
      .addr_hi(arr_addr[15:14]), .special(mode_special), .page_sel(page_sel),
      .blk_sel(blk_sel), .map_ok(map_ok)
   );

   fseq_ctrl #(.DATA_W(DATA_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .special(mode_special), .map_ok(map_ok),
      .stop_req(stop_req), .arr_wr(arr_wr), .arr_byte(arr_byte), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .tmr_done(tmr_done), .st(st), .acc_err(acc_err), .launch(launch),
      .l_cmd(launch_cmd), .l_addr(launch_addr), .l_data(launch_data),
      .tmr_start(tmr_start), .tmr_long(tmr_long)
   );

   fseq_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) tmr_i (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .long_op(tmr_long), .done(tmr_done)
   );

   assign buf_empty = (st != ST_RUN);
   assign cmd_done  = (st != ST_RUN);

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stop_req,
   input logic       arr_wr,
   input logic       arr_byte,
   input logic       arr_lsb,
   input logic       reg_wr,
   input logic [1:0] reg_idx,
   input logic [7:0] reg_wdata,
   input logic       buf_empty,
   input logic       cmd_done,
   input logic       acc_err,
   input logic       launch
);
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (buf_empty && cmd_done && !acc_err && !launch));

   assert_launch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !launch);

   assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> (!buf_empty && !cmd_done));

   assert_byte_odd_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr && (arr_byte || arr_lsb) && !stop_req) |=> acc_err);

   assert_busy_write_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr && !buf_empty && !stop_req) |=> acc_err);

   assert_stop_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !buf_empty) |=> (buf_empty && acc_err));

   assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_err && !(reg_wr && reg_idx == 2'd2 && reg_wdata[4])) |=> acc_err);

   assert_launch_clean_R13: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !$past(acc_err));

endmodule

bind flash_seq_guard fseq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .arr_wr(arr_wr),
   .arr_byte(arr_byte), .arr_lsb(arr_addr[0]), .reg_wr(reg_wr), .reg_idx(reg_idx),
   .reg_wdata(reg_wdata), .buf_empty(buf_empty), .cmd_done(cmd_done),
   .acc_err(acc_err), .launch(launch)
);

// File: tb/flash_seq_guard_tb_top.sv
`timescale 1ns/1ps
module flash_seq_guard_tb_top;
   localparam int DW = 16;
   localparam int PW = 6;
   localparam int PROG_N  = 16;
   localparam int ERASE_N = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_special = 1'b0;
   logic [PW-1:0] page_sel = 6'h3C;
   logic          blk_sel = 1'b0;
   logic          stop_req = 1'b0;
   logic          arr_wr = 1'b0, arr_byte = 1'b0;
   logic [15:0]   arr_addr = '0;
   logic [DW-1:0] arr_wdata = '0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_idx = '0;
   logic [7:0]    reg_wdata = '0;
   logic          buf_empty, cmd_done, acc_err, launch;
   logic [7:0]    launch_cmd;
   logic [15:0]   launch_addr;
   logic [DW-1:0] launch_data;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   flash_seq_guard #(
      .DATA_W(DW), .PAGE_W(PW), .PAGE_BASE(60), .NUM_PAGES(4), .BLK_ID(1'b0),
      .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_special(mode_special), .page_sel(page_sel),
      .blk_sel(blk_sel), .stop_req(stop_req), .arr_wr(arr_wr), .arr_byte(arr_byte),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .reg_wr(reg_wr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .buf_empty(buf_empty), .cmd_done(cmd_done),
      .acc_err(acc_err), .launch(launch), .launch_cmd(launch_cmd),
      .launch_addr(launch_addr), .launch_data(launch_data)
   );

   function automatic int exp_cycles(input logic [7:0] c);
      return (c == 8'h40 || c == 8'h41) ? ERASE_N : PROG_N;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic arr_write(input logic [15:0] a, input logic [DW-1:0] d, input logic byt);
      arr_wr = 1'b1; arr_addr = a; arr_wdata = d; arr_byte = byt;
      @(negedge clk);
      arr_wr = 1'b0; arr_byte = 1'b0;
   endtask

   task automatic reg_write(input logic [1:0] idx, input logic [7:0] d);
      reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic clear_err();
      reg_write(2'd2, 8'h10);
   endtask

   task automatic pulse_stop();
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
   endtask

   task automatic full_seq(input logic [15:0] a, input logic [DW-1:0] d, input logic [7:0] c);
      int n;
      arr_write(a, d, 1'b0);
      reg_write(2'd3, c);
      reg_write(2'd2, 8'h80);
      chk("R2 launch pulse", launch, 1);
      chk("R2 launch code", launch_cmd, c);
      chk("R2 launch addr", launch_addr, a);
      chk("R2 launch data", launch_data, d);
      chk("R2 buf_empty low", buf_empty, 0);
      chk("R2 cmd_done low", cmd_done, 0);
      n = exp_cycles(c);
      repeat (n - 1) @(negedge clk);
      chk("R3 still busy at last cycle", buf_empty, 0);
      chk("R2 pulse one cycle", launch, 0);
      @(negedge clk);
      chk("R3 buf_empty back", buf_empty, 1);
      chk("R3 cmd_done back", cmd_done, 1);
      chk("R3 no error", acc_err, 0);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] codes [4];
      codes[0] = 8'h05; codes[1] = 8'h20; codes[2] = 8'h40; codes[3] = 8'h41;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 buf_empty", buf_empty, 1);
      chk("R1 cmd_done", cmd_done, 1);
      chk("R1 acc_err", acc_err, 0);
      chk("R1 launch", launch, 0);

      // R4: array write before divider is set
      arr_write(16'h1000, 16'h1234, 1'b0);
      chk("R4 no divider", acc_err, 1);
      clear_err();
      chk("R13 w1c clears", acc_err, 0);
      reg_write(2'd0, 8'h2A);

      // R14: code and launch with no word
      reg_write(2'd3, 8'h20);
      chk("R14 code alone no err", acc_err, 0);
      reg_write(2'd2, 8'h80);
      chk("R14 launch alone no launch", launch, 0);
      chk("R14 launch alone idle", buf_empty, 1);

      // R2/R3 random legal sequences
      for (int i = 0; i < 16; i++) begin
         logic [15:0] a;
         a = 16'($urandom) & 16'hFFFE;
         full_seq(a, 16'($urandom), codes[$urandom % 4]);
      end

      // R5
      arr_write(16'h2000, 16'h00FF, 1'b1);
      chk("R5 byte write", acc_err, 1);
      clear_err();
      arr_write(16'h2001, 16'h00FF, 1'b0);
      chk("R5 odd address", acc_err, 1);
      clear_err();

      // R7: second word aborts the whole sequence
      arr_write(16'h3000, 16'h1111, 1'b0);
      arr_write(16'h3002, 16'h2222, 1'b0);
      chk("R7 second word", acc_err, 1);
      clear_err();
      reg_write(2'd3, 8'h20);
      reg_write(2'd2, 8'h80);
      chk("R7 aborted no launch", launch, 0);
      chk("R7 aborted idle", buf_empty, 1);

      // R8
      arr_write(16'h3000, 16'h1111, 1'b0);
      reg_write(2'd1, 8'h00);
      chk("R8 config after word", acc_err, 1);
      clear_err();
      arr_write(16'h3000, 16'h1111, 1'b0);
      reg_write(2'd2, 8'h80);
      chk("R8 status after word", acc_err, 1);
      chk("R8 status after word no launch", launch, 0);
      clear_err();

      // R9
      arr_write(16'h3000, 16'h1111, 1'b0);
      reg_write(2'd3, 8'h20);
      reg_write(2'd3, 8'h40);
      chk("R9 second code", acc_err, 1);
      clear_err();
      arr_write(16'h3000, 16'h1111, 1'b0);
      reg_write(2'd3, 8'h33);
      chk("R9 unknown code normal mode", acc_err, 1);
      clear_err();
      mode_special = 1'b1;
      full_seq(16'h4000, 16'h5A5A, 8'h33);
      mode_special = 1'b0;

      // R10
      arr_write(16'h3000, 16'h1111, 1'b0);
      reg_write(2'd3, 8'h20);
      reg_write(2'd0, 8'h2A);
      chk("R10 divider after code", acc_err, 1);
      clear_err();
      reg_write(2'd2, 8'h80);
      chk("R10 aborted no launch", launch, 0);

      // R6: array write during run
      arr_write(16'h1000, 16'hBEEF, 1'b0);
      reg_write(2'd3, 8'h20);
      reg_write(2'd2, 8'h80);
      arr_write(16'h1002, 16'h0001, 1'b0);
      chk("R6 busy write err", acc_err, 1);
      chk("R6 still busy", buf_empty, 0);
      repeat (PROG_N - 2) @(negedge clk);
      chk("R6 run keeps schedule busy", buf_empty, 0);
      @(negedge clk);
      chk("R6 run completes", buf_empty, 1);
      clear_err();

      // R11
      blk_sel = 1'b1;
      arr_write(16'h1000, 16'h0000, 1'b0);
      chk("R11 normal wrong block", acc_err, 1);
      clear_err();
      blk_sel = 1'b0;
      mode_special = 1'b1;
      page_sel = 6'h10;
      arr_write(16'h9000, 16'h0000, 1'b0);
      chk("R11 special bad page", acc_err, 1);
      clear_err();
      arr_write(16'h4000, 16'h0000, 1'b0);
      chk("R11 special outside window", acc_err, 0);
      pulse_stop();
      chk("R12 stop pending no err", acc_err, 0);
      reg_write(2'd3, 8'h20);
      reg_write(2'd2, 8'h80);
      chk("R12 stop killed pending", launch, 0);
      page_sel = 6'h3D;
      full_seq(16'h9000, 16'hC0DE, 8'h20);
      blk_sel = 1'b1;
      arr_write(16'h9000, 16'h0000, 1'b0);
      chk("R11 special wrong block", acc_err, 1);
      clear_err();
      blk_sel = 1'b0;
      mode_special = 1'b0;

      // R12: stop during run
      arr_write(16'h0100, 16'h7777, 1'b0);
      reg_write(2'd3, 8'h40);
      reg_write(2'd2, 8'h80);
      repeat (2) @(negedge clk);
      pulse_stop();
      chk("R12 stop buf_empty", buf_empty, 1);
      chk("R12 stop cmd_done", cmd_done, 1);
      chk("R12 stop err", acc_err, 1);

      // R13: while error set, sequences cannot start
      arr_write(16'h0200, 16'h1212, 1'b0);
      reg_write(2'd3, 8'h20);
      reg_write(2'd2, 8'h80);
      chk("R13 blocked no launch", launch, 0);
      chk("R13 blocked idle", buf_empty, 1);
      chk("R13 sticky", acc_err, 1);
      clear_err();
      full_seq(16'h0200, 16'h1212, 8'h05);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule